// File: doc/BRIEF.md
# Video Processor Host Control Port

This block is the processor-facing side of a video display processor. The host sees two byte-wide locations, chosen by one select bit: the data location (select 0) and the control location (select 1). Bytes written to the control location pair up. The first byte of a pair goes into the low half of the video memory pointer at once. The second byte supplies the upper pointer bits, and its two top bits choose the command: queue a memory read, set up for a later write, load a numbered configuration register with the first byte, or select the colour memory.

A write to the data location puts its byte in a one-byte read-ahead buffer and asks the memory arbiter for a write. A read from the data location returns that buffer and asks for the next read. Every access request waits a fixed number of cycles before it is raised, and it stays up until the arbiter acknowledges it. Each acknowledged access moves the pointer on by one. A read from the control location returns the status byte and clears its event flags. Any read, and any data write, puts the byte pairing back to the first-byte state.

The register contents come out as a flat bus, with the display-control and colour fields also decoded. An interrupt output combines the frame and line events with their enables.

Top module: `vdp_host_port`

## Requirements
- R1: After reset the pointer, all configuration registers, the status byte, the read-ahead buffer, the colour-memory select, the access request and the interrupt output are all zero.
- R2: A control write while the pair phase is clear loads pointer bits [7:0] with the byte on the following edge, keeps the byte as the pending register value, and sets the pair phase.
- R3: A control write while the pair phase is set always loads pointer bits [13:8] with byte bits [5:0] and clears the phase. When byte bits [7:6] are 00 it queues a memory read. When bit 7 is 0 it deselects the colour memory.
- R4: A second control byte with bits [7:6] = 10 writes the pending first byte into the register numbered by bits [3:0]. With bits [7:6] = 11 it selects the colour memory and leaves every register unchanged.
- R5: Register 1 decodes as bit 6 display enable, bit 5 frame interrupt enable, bits 4 and 3 the two mode bits, bit 1 large sprites and bit 0 sprite magnification. Register 7 gives the foreground colour in bits [7:4] and the background colour in bits [3:0]. Register 0 bit 4 is the line interrupt enable.
- R6: A data write stores its byte in the read-ahead buffer, clears the pair phase and queues a memory write. The write data offered to the arbiter is the buffer.
- R7: Any host read clears the pair phase. A data read returns the read-ahead buffer in the same cycle and queues a memory read.
- R8: The access request rises exactly ACC_DELAY cycles after the edge that queued it and holds until acknowledged. A newly queued access replaces a waiting one, takes its direction and restarts the delay.
- R9: An acknowledged access advances the 14-bit pointer by one, wrapping to zero. An acknowledged read loads the read-ahead buffer with the returned byte, except that a host data write in the same cycle wins the buffer.
- R10: The status byte holds the frame event in bit 7, overflow in bit 6, collision in bit 5 and the last reported sprite number in bits [4:0]. The sprite number is updated only while overflow is clear. A status read returns the byte and clears bits 7 to 5 and the pending line event; an event arriving in the same cycle stays set.
- R11: The interrupt output is high when the frame flag and frame interrupt enable are both set, or when a line event is pending and the line interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_sel | input | 1 | 0 = data location, 1 = control location |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of the read strobe |
| acc_req | output | 1 | Memory access request to the arbiter |
| acc_we | output | 1 | Direction of the request, 1 = write |
| acc_addr | output | AW | Memory address of the request (the pointer) |
| acc_wdata | output | 8 | Write byte of the request (the read-ahead buffer) |
| acc_ack | input | 1 | Arbiter acknowledge, taken while acc_req is high |
| acc_rdata | input | 8 | Byte returned by the arbiter for a read |
| ev_frame | input | 1 | Frame event pulse |
| ev_overflow | input | 1 | Sprite overflow event pulse |
| ev_collision | input | 1 | Sprite collision event pulse |
| ev_line | input | 1 | Line event pulse |
| ev_sprite_vld | input | 1 | Sprite number report strobe |
| ev_sprite | input | 5 | Reported sprite number |
| cfg_flat | output | NUM_REGS*8 | All configuration registers, register n in bits [8n+7:8n] |
| disp_en | output | 1 | Display enable |
| frame_irq_en | output | 1 | Frame interrupt enable |
| line_irq_en | output | 1 | Line interrupt enable |
| mode_a | output | 1 | Mode bit from register 1 bit 4 |
| mode_b | output | 1 | Mode bit from register 1 bit 3 |
| spr_large | output | 1 | Large sprite select |
| spr_mag | output | 1 | Sprite magnification |
| fg_colour | output | 4 | Foreground colour |
| bg_colour | output | 4 | Background colour |
| cram_sel | output | 1 | Colour memory selected |
| irq | output | 1 | Interrupt output |

## Verification
Two pairs of functions can act in the same cycle. In the first, a status read clears the flags while the video side reports a new frame event. The bench raises both strobes at the same edge. It expects the read to return the old byte with bit 7 clear and a following read to show the event kept. In the second, an arbiter acknowledge of a pending read carries one byte while the host writes another byte to the data location in that cycle. A later data read must return the host's byte.

// File: rtl/vdp_host_port.sv
module vdp_host_port #(
  parameter int AW        = 14,
  parameter int NUM_REGS  = 16,
  parameter int ACC_DELAY = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic                  host_sel,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  output logic                  acc_req,
  output logic                  acc_we,
  output logic [AW-1:0]         acc_addr,
  output logic [7:0]            acc_wdata,
  input  logic                  acc_ack,
  input  logic [7:0]            acc_rdata,
  input  logic                  ev_frame,
  input  logic                  ev_overflow,
  input  logic                  ev_collision,
  input  logic                  ev_line,
  input  logic                  ev_sprite_vld,
  input  logic [4:0]            ev_sprite,
  output logic [NUM_REGS*8-1:0] cfg_flat,
  output logic                  disp_en,
  output logic                  frame_irq_en,
  output logic                  line_irq_en,
  output logic                  mode_a,
  output logic                  mode_b,
  output logic                  spr_large,
  output logic                  spr_mag,
  output logic [3:0]            fg_colour,
  output logic [3:0]            bg_colour,
  output logic                  cram_sel,
  output logic                  irq
);

  localparam int DCW = $clog2(ACC_DELAY + 1);
  localparam int HIW = AW - 8;

  logic            phase_q;
  logic [7:0]      first_q;
  logic [AW-1:0]   ptr_q;
  logic [7:0]      rab_q;
  logic            pend_q;
  logic            pend_we_q;
  logic [DCW-1:0]  dly_q;
  logic [7:0]      status_q;
  logic            line_pend_q;
  logic            cram_q;
  logic [7:0]      cfg_q [NUM_REGS];

  wire data_wr  = host_wr & ~host_sel;
  wire ctrl_wr  = host_wr &  host_sel;
  wire data_rd  = host_rd & ~host_sel;
  wire stat_rd  = host_rd &  host_sel;
  wire ctrl_1st = ctrl_wr & ~phase_q;
  wire ctrl_2nd = ctrl_wr &  phase_q;
  wire cmd_reg  = ctrl_2nd & (host_wdata[7:6] == 2'b10);
  wire cmd_cram = ctrl_2nd & (host_wdata[7:6] == 2'b11);
  wire cmd_read = ctrl_2nd & (host_wdata[7:6] == 2'b00);
  wire q_read   = cmd_read | data_rd;
  wire queue    = data_wr | q_read;
  wire ack      = acc_req & acc_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    phase_q <= 1'b0;
    else if (host_rd || data_wr)   phase_q <= 1'b0;
    else if (ctrl_wr)              phase_q <= ~phase_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        first_q <= '0;
    else if (ctrl_1st) first_q <= host_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ptr_q <= '0;
    else if (ctrl_1st) ptr_q[7:0] <= host_wdata;
    else if (ctrl_2nd) ptr_q[AW-1:8] <= host_wdata[HIW-1:0];
    else if (ack)      ptr_q <= ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  rab_q <= '0;
    else if (data_wr)            rab_q <= host_wdata;
    else if (ack && !pend_we_q)  rab_q <= acc_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_we_q <= 1'b0;
      dly_q     <= '0;
    end else if (queue) begin
      pend_q    <= 1'b1;
      pend_we_q <= data_wr;
      dly_q     <= DCW'(ACC_DELAY);
    end else begin
      if (ack)        pend_q <= 1'b0;
      if (dly_q != 0) dly_q  <= dly_q - 1'b1;
    end

  assign acc_req   = pend_q & (dly_q == 0);
  assign acc_we    = pend_we_q;
  assign acc_addr  = ptr_q;
  assign acc_wdata = rab_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cram_q <= 1'b0;
    else if (cmd_cram)               cram_q <= 1'b1;
    else if (ctrl_2nd && !host_wdata[7]) cram_q <= 1'b0;

  assign cram_sel = cram_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg_q[g] <= '0;
      else if (cmd_reg && host_wdata[3:0] == 4'(g)) cfg_q[g] <= first_q;
    assign cfg_flat[g*8 +: 8] = cfg_q[g];
  end

  assign line_irq_en  = cfg_q[0][4];
  assign disp_en      = cfg_q[1][6];
  assign frame_irq_en = cfg_q[1][5];
  assign mode_a       = cfg_q[1][4];
  assign mode_b       = cfg_q[1][3];
  assign spr_large    = cfg_q[1][1];
  assign spr_mag      = cfg_q[1][0];
  assign fg_colour    = cfg_q[7][7:4];
  assign bg_colour    = cfg_q[7][3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_q    <= '0;
      line_pend_q <= 1'b0;
    end else begin
      status_q[7] <= ev_frame     | (status_q[7] & ~stat_rd);
      status_q[6] <= ev_overflow  | (status_q[6] & ~stat_rd);
      status_q[5] <= ev_collision | (status_q[5] & ~stat_rd);
      if (ev_sprite_vld && !status_q[6]) status_q[4:0] <= ev_sprite;
      line_pend_q <= ev_line | (line_pend_q & ~stat_rd);
    end

  assign host_rdata = host_sel ? status_q : rab_q;
  assign irq = (status_q[7] & frame_irq_en) | (line_pend_q & line_irq_en);

  AST_PTR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_1st |=> (ptr_q[7:0] == $past(host_wdata))); // R2
  AST_READ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !phase_q); // R7
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    queue |=> !acc_req); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack && !queue) |=> acc_req); // R8
  AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ctrl_wr) |=> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R9
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_frame) |=> !status_q[7]); // R10

endmodule

// File: tb/vdp_host_port_bench.sv
module vdp_host_port_bench;
  localparam int AW = 14, NR = 16, DLY = 3;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic acc_req, acc_we, acc_ack = 0;
  logic [AW-1:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata = 0;
  logic ev_frame = 0, ev_overflow = 0, ev_collision = 0, ev_line = 0, ev_sprite_vld = 0;
  logic [4:0] ev_sprite = 0;
  logic [NR*8-1:0] cfg_flat;
  logic disp_en, frame_irq_en, line_irq_en, mode_a, mode_b, spr_large, spr_mag, cram_sel, irq;
  logic [3:0] fg_colour, bg_colour;

  int checks = 0, errors = 0;
  logic [7:0] last_rd;

  always #10 clk = ~clk;

  vdp_host_port #(.AW(AW), .NUM_REGS(NR), .ACC_DELAY(DLY)) u_vdp_host_port (
    .clk, .rst_n, .host_wr, .host_rd, .host_sel, .host_wdata, .host_rdata,
    .acc_req, .acc_we, .acc_addr, .acc_wdata, .acc_ack, .acc_rdata,
    .ev_frame, .ev_overflow, .ev_collision, .ev_line, .ev_sprite_vld, .ev_sprite,
    .cfg_flat, .disp_en, .frame_irq_en, .line_irq_en, .mode_a, .mode_b,
    .spr_large, .spr_mag, .fg_colour, .bg_colour, .cram_sel, .irq);

  // op: 0 data write, 1 control write, 2 data read, 3 status read
  // chk: 0 none, 1 ptr[7:0], 2 ptr[13:8], 3 reg1, 4 reg7, 5 cram_sel, 6 read byte, 7 reg0
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 8'h34, 4'd1, 8'h34},   // R2
    {4'd1, 8'h12, 4'd2, 8'h12},   // R3
    {4'd1, 8'hE5, 4'd0, 8'h00},
    {4'd1, 8'h81, 4'd3, 8'hE5},   // R4
    {4'd1, 8'h4B, 4'd0, 8'h00},
    {4'd1, 8'h87, 4'd4, 8'h4B},   // R4
    {4'd1, 8'h10, 4'd0, 8'h00},
    {4'd1, 8'h80, 4'd7, 8'h10},   // R4
    {4'd1, 8'h00, 4'd0, 8'h00},
    {4'd1, 8'hC1, 4'd5, 8'h01},   // R4 colour select
    {4'd0, 8'h00, 4'd3, 8'hE5},   // R4 reg1 untouched by colour select
    {4'd1, 8'h00, 4'd0, 8'h00},
    {4'd1, 8'h40, 4'd5, 8'h00},   // R3 deselect
    {4'd1, 8'h77, 4'd1, 8'h77},
    {4'd2, 8'h00, 4'd0, 8'h00},
    {4'd1, 8'h21, 4'd1, 8'h21},   // R7 phase cleared by data read
    {4'd0, 8'h5A, 4'd0, 8'h00},
    {4'd1, 8'h66, 4'd1, 8'h66},   // R6 phase cleared by data write
    {4'd1, 8'hFF, 4'd2, 8'h3F},   // R3 upper bits always loaded
    {4'd1, 8'h44, 4'd1, 8'h44},
    {4'd3, 8'h00, 4'd6, 8'h00},   // R10 empty status
    {4'd1, 8'h55, 4'd1, 8'h55},   // R7 phase cleared by status read
    {4'd2, 8'h00, 4'd6, 8'h5A},   // R7 buffer returned
    {4'd1, 8'h08, 4'd1, 8'h08},
    {4'd1, 8'h80, 4'd7, 8'h08},   // R4
    {4'd1, 8'hA3, 4'd1, 8'hA3},
    {4'd1, 8'h00, 4'd2, 8'h00}    // R3
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [3:0] op, logic [7:0] d);
    @(negedge clk);
    host_wr = (op <= 1); host_rd = (op >= 2); host_sel = op[0]; host_wdata = d;
    #2 last_rd = host_rdata;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_req(string req, logic exp_we);
    repeat (DLY - 1) @(posedge clk);
    #1 check({req, " request not early"}, acc_req, 0);
    @(posedge clk); #1;
    check({req, " request after delay"}, acc_req, 1);
    check({req, " request direction"}, acc_we, exp_we);
  endtask

  task automatic pulse(logic f, logic o, logic c, logic l, logic sv, logic [4:0] s);
    @(negedge clk);
    ev_frame = f; ev_overflow = o; ev_collision = c; ev_line = l; ev_sprite_vld = sv; ev_sprite = s;
    @(posedge clk); #1;
    ev_frame = 0; ev_overflow = 0; ev_collision = 0; ev_line = 0; ev_sprite_vld = 0;
  endtask

  function automatic logic [7:0] observe(logic [3:0] c);
    case (c)
      4'd1: return acc_addr[7:0];
      4'd2: return {2'b00, acc_addr[13:8]};
      4'd3: return cfg_flat[15:8];
      4'd4: return cfg_flat[63:56];
      4'd5: return {7'd0, cram_sel};
      4'd6: return last_rd;
      4'd7: return cfg_flat[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] c);
    case (c)
      4'd1: return "R2/R7 pointer low";
      4'd2: return "R3 pointer high";
      4'd3, 4'd4, 4'd7: return "R4 register write";
      4'd5: return "R3/R4 colour select";
      default: return "R7/R10 read byte";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 pointer", acc_addr, 0);
    check("R1 registers", cfg_flat, 0);
    check("R1 request", acc_req, 0);
    check("R1 colour select", cram_sel, 0);
    check("R1 irq", irq, 0);
    check("R1 buffer", acc_wdata, 0);
    do_op(4'd3, 8'h00);
    check("R1 status", last_rd, 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][23:20], VEC[i][19:12]);
      if (VEC[i][11:8] != 0)
        check(req_of(VEC[i][11:8]), observe(VEC[i][11:8]), VEC[i][7:0]);
    end

    // R5 field decode
    do_reset();
    do_op(4'd1, 8'h5B); do_op(4'd1, 8'h81);
    check("R5 reg1 fields", {disp_en, frame_irq_en, mode_a, mode_b, spr_large, spr_mag}, 6'b101111);
    do_op(4'd1, 8'hC9); do_op(4'd1, 8'h87);
    check("R5 colours", {fg_colour, bg_colour}, 8'hC9);

    // R6 R8 write request timing and hold
    do_reset();
    do_op(4'd0, 8'hA5);
    check("R6 request not at once", acc_req, 0);
    wait_req("R6", 1'b1);
    check("R6 write data", acc_wdata, 8'hA5);
    repeat (5) @(posedge clk);
    #1 check("R8 request held", acc_req, 1);
    @(negedge clk); acc_ack = 1;
    @(posedge clk); #1 acc_ack = 0;
    check("R8 request dropped after ack", acc_req, 0);
    check("R9 pointer advanced", acc_addr, 1);

    // R3 R9 read request, wrap, buffer load
    do_op(4'd1, 8'hFF); do_op(4'd1, 8'h3F);
    wait_req("R3 read", 1'b0);
    check("R3 read address", acc_addr, 14'h3FFF);
    @(negedge clk); acc_ack = 1; acc_rdata = 8'h6C;
    @(posedge clk); #1 acc_ack = 0;
    check("R9 pointer wraps", acc_addr, 0);
    do_op(4'd2, 8'h00);
    check("R7 data read returns fetched byte", last_rd, 8'h6C);
    wait_req("R7 next read", 1'b0);

    // R8 replacement
    do_op(4'd0, 8'h11); do_op(4'd1, 8'h00); do_op(4'd1, 8'h00);
    wait_req("R8 replaced request", 1'b0);

    // R9 host write wins buffer over read acknowledge
    @(negedge clk);
    host_wr = 1; host_sel = 0; host_wdata = 8'h33; acc_ack = 1; acc_rdata = 8'hEE;
    @(posedge clk); #1 host_wr = 0; acc_ack = 0;
    do_op(4'd2, 8'h00);
    check("R9 host write wins buffer", last_rd, 8'h33);

    // R10 R11 status and interrupt
    do_reset();
    do_op(4'd1, 8'h20); do_op(4'd1, 8'h81);
    pulse(0, 0, 0, 0, 1, 5'd5);
    pulse(0, 1, 0, 0, 0, 5'd0);
    pulse(0, 0, 0, 0, 1, 5'd9);
    check("R11 irq low without frame event", irq, 0);
    pulse(1, 0, 1, 1, 0, 5'd0);
    check("R11 frame irq", irq, 1);
    do_op(4'd3, 8'h00);
    check("R10 status byte", last_rd, 8'hE5);
    check("R11 irq cleared by status read", irq, 0);
    do_op(4'd3, 8'h00);
    check("R10 flags cleared", last_rd, 8'h05);
    do_op(4'd1, 8'h10); do_op(4'd1, 8'h80);
    check("R11 no stale line event", irq, 0);
    pulse(0, 0, 0, 1, 0, 5'd0);
    check("R11 line irq", irq, 1);
    do_op(4'd3, 8'h00);
    check("R10 line event cleared", irq, 0);

    // R10 event in same cycle as status read
    @(negedge clk);
    host_rd = 1; host_sel = 1; ev_frame = 1;
    #2 last_rd = host_rdata;
    @(posedge clk); #1 host_rd = 0; ev_frame = 0;
    check("R10 read shows old byte", last_rd, 8'h05);
    do_op(4'd3, 8'h00);
    check("R10 same-cycle event kept", last_rd, 8'h85);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule